// File: doc/BRIEF.md
# Outer-Product Quantized Multiply-Accumulate Array

This block is a two-dimensional array of dot-product cells that computes a quantized outer product. It has N rows and M columns. Row r takes weight lane r, and that lane's K signed 8-bit values reach every cell of the row. Column c takes activation lane c, which carries one batch of K signed 8-bit values; the batches arrive in transposed order, one per column. In each cycle every cell forms a K-term signed dot product of its weight lane and its activation lane, so the array performs N×M×K multiply-accumulates per cycle. With the defaults (8, 8, 4) that is 256 per cycle.

Each cell keeps its result in its own 32-bit accumulator. Three operations can apply to the accumulators, chosen from the two control inputs. In ACC_HOLD (no valid input) the accumulators keep their values. In ACC_LOAD (valid input with clear) each accumulator takes the new dot product. In ACC_ADD (valid input without clear) each accumulator adds the new dot product to its value. Sums wrap modulo 2^32. A row index selects one row of M accumulators, which appears on the read port.

Top module: `outer_mac_array`

## Requirements
- R1: After reset every accumulator is zero, so every row reads back as all zeros.
- R2: When `in_valid`=1 and `in_clear`=1, each cell (r,c) loads the dot product of its operand lanes and discards its old value.
- R3: When `in_valid`=1 and `in_clear`=0, each cell (r,c) adds the dot product to its accumulator.
- R4: When `in_valid`=0, the accumulators keep their values, whatever is on `in_clear` and the operand inputs.
- R5: Operands are signed two's-complement bytes. The dot product is the sum of the K sign-extended 16-bit products, for example (-128)·(-128)=16384 and (-128)·127=-16256.
- R6: An accumulator wraps modulo 2^32 on overflow and does not saturate.
- R7: Weight lane r, element k sits at `wgt_i[(r*K+k)*8 +: 8]` and feeds only row r. Activation lane c, element k sits at `act_i[(c*K+k)*8 +: 8]` and feeds only column c. Cell (r,c) uses the elements with the same k.
- R8: `rd_data[c*32 +: 32]` shows the accumulator of cell (`rd_row`, c), combinationally from the registered state.
- R9: An accumulator update appears on `rd_data` one clock edge after the valid input, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| in_clear | input | 1 | Load rather than add (qualified by in_valid) |
| wgt_i | input | N*K*8 (256) | Weight lanes, one per row |
| act_i | input | M*K*8 (256) | Activation batch lanes, one per column |
| rd_row | input | clog2(N) (3) | Row index for readout |
| rd_data | output | M*32 (256) | Accumulators of the selected row |

## Verification
The assertions check on every cycle that reset leaves the array at zero, that an idle cycle leaves the selected row unchanged, and that a zero weight vector either zeroes the row on a load or leaves it unchanged on an add. The bench scenarios are needed for the arithmetic itself: the signed products, the pairing of lanes between rows and columns, the wrap after 65536 maximal additions, and the one-edge latency. These need a reference model of the expected sums.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DEF_DATA_W = 8;
    localparam int DEF_ACC_W  = 32;

    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_ADD  = 2'd2
    } acc_op_e;

endpackage

// File: rtl/mac_dot_cell.sv
module mac_dot_cell
    import mac_pkg::*;
#(
    parameter int K      = 4,
    parameter int DATA_W = DEF_DATA_W,
    parameter int ACC_W  = DEF_ACC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  acc_op_e               op,
    input  logic [K*DATA_W-1:0]   w_vec,
    input  logic [K*DATA_W-1:0]   a_vec,
    output logic [ACC_W-1:0]      acc_o
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [ACC_W-1:0] dot;
    logic        [ACC_W-1:0] acc_q;

    always_comb begin
        dot = '0;
        for (int k = 0; k < K; k++) begin
            logic signed [DATA_W-1:0] wv;
            logic signed [DATA_W-1:0] av;
            logic signed [PROD_W-1:0] pr;
            wv  = w_vec[k*DATA_W +: DATA_W];
            av  = a_vec[k*DATA_W +: DATA_W];
            pr  = wv * av;
            dot = dot + ACC_W'(pr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            unique case (op)
                ACC_HOLD: acc_q <= acc_q;
                ACC_LOAD: acc_q <= dot;
                ACC_ADD:  acc_q <= acc_q + dot;
                default:  acc_q <= acc_q;
            endcase
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/mac_row.sv
module mac_row
    import mac_pkg::*;
#(
    parameter int M      = 8,
    parameter int K      = 4,
    parameter int DATA_W = DEF_DATA_W,
    parameter int ACC_W  = DEF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  acc_op_e                 op,
    input  logic [K*DATA_W-1:0]     w_lane,
    input  logic [M*K*DATA_W-1:0]   act_all,
    output logic [M*ACC_W-1:0]      row_acc_o
);
    localparam int LANE_W = K * DATA_W;

    for (genvar c = 0; c < M; c++) begin : g_col
        mac_dot_cell #(
            .K      (K),
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .op    (op),
            .w_vec (w_lane),
            .a_vec (act_all[c*LANE_W +: LANE_W]),
            .acc_o (row_acc_o[c*ACC_W +: ACC_W])
        );
    end

endmodule

// File: rtl/outer_mac_array.sv
module outer_mac_array
    import mac_pkg::*;
#(
    parameter int N      = 8,
    parameter int M      = 8,
    parameter int K      = 4,
    parameter int DATA_W = DEF_DATA_W,
    parameter int ACC_W  = DEF_ACC_W,
    localparam int ROW_W  = (N > 1) ? $clog2(N) : 1,
    localparam int LANE_W = K * DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_clear,
    input  logic [N*LANE_W-1:0]    wgt_i,
    input  logic [M*LANE_W-1:0]    act_i,
    input  logic [ROW_W-1:0]       rd_row,
    output logic [M*ACC_W-1:0]     rd_data
);
    acc_op_e            op;
    logic [M*ACC_W-1:0] row_acc [N];

    always_comb begin
        unique case ({in_valid, in_clear})
            2'b11:   op = ACC_LOAD;
            2'b10:   op = ACC_ADD;
            default: op = ACC_HOLD;
        endcase
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        mac_row #(
            .M      (M),
            .K      (K),
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) row_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .op        (op),
            .w_lane    (wgt_i[r*LANE_W +: LANE_W]),
            .act_all   (act_i),
            .row_acc_o (row_acc[r])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < N; r++) begin
            if (int'(rd_row) == r) rd_data = row_acc[r];
        end
    end

endmodule

// File: rtl/mac_array_chk.sv
module mac_array_chk #(
    parameter int N      = 8,
    parameter int M      = 8,
    parameter int K      = 4,
    parameter int DATA_W = 8,
    parameter int ACC_W  = 32,
    localparam int ROW_W = (N > 1) ? $clog2(N) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_clear,
    input logic [N*K*DATA_W-1:0]   wgt_i,
    input logic [ROW_W-1:0]        rd_row,
    input logic [M*ACC_W-1:0]      rd_data
);
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!$stable(rd_row) || $stable(rd_data))); // R4

    AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_clear && (wgt_i == '0)) |=> (rd_data == '0)); // R2

    AST_ZERO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_clear && (wgt_i == '0)) |=> (!$stable(rd_row) || $stable(rd_data))); // R3

endmodule

bind outer_mac_array mac_array_chk #(
    .N      (N),
    .M      (M),
    .K      (K),
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_clear (in_clear),
    .wgt_i    (wgt_i),
    .rd_row   (rd_row),
    .rd_data  (rd_data)
);

// File: tb/outer_mac_array_tb_top.sv
`timescale 1ns/100ps
module outer_mac_array_tb_top;
    localparam int N  = 8;
    localparam int M  = 8;
    localparam int K  = 4;
    localparam int DW = 8;
    localparam int AW = 32;
    localparam int RW = $clog2(N);

    typedef struct packed {
        logic       vld;
        logic       clr;
        logic [7:0] wb;
        logic [7:0] ab;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 8'h05, 8'h10},
        '{1'b1, 1'b0, 8'hF0, 8'h22},
        '{1'b0, 1'b1, 8'h7F, 8'h80},
        '{1'b1, 1'b0, 8'h80, 8'h7F},
        '{1'b1, 1'b1, 8'hC3, 8'h3C},
        '{1'b1, 1'b0, 8'h01, 8'hFF},
        '{1'b0, 1'b0, 8'h00, 8'h00},
        '{1'b1, 1'b0, 8'h44, 8'hAA}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_clear = 1'b0;
    logic [N*K*DW-1:0] wgt_i = '0;
    logic [M*K*DW-1:0] act_i = '0;
    logic [RW-1:0]     rd_row = '0;
    logic [M*AW-1:0]   rd_data;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    logic [AW-1:0] mdl [N][M];

    always #2 clk = ~clk;

    outer_mac_array #(.N(N), .M(M), .K(K), .DATA_W(DW), .ACC_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_clear(in_clear),
        .wgt_i(wgt_i), .act_i(act_i), .rd_row(rd_row), .rd_data(rd_data)
    );

    function automatic logic [AW-1:0] dot_of(int r, int c);
        int s = 0;
        for (int k = 0; k < K; k++) begin
            logic signed [7:0] w8;
            logic signed [7:0] a8;
            w8 = wgt_i[(r*K+k)*DW +: DW];
            a8 = act_i[(c*K+k)*DW +: DW];
            s += int'(w8) * int'(a8);
        end
        return AW'(s);
    endfunction

    task automatic set_ops(logic [7:0] wb, logic [7:0] ab);
        for (int r = 0; r < N; r++)
            for (int k = 0; k < K; k++)
                wgt_i[(r*K+k)*DW +: DW] = 8'(wb + 8'(r*3) + 8'(k));
        for (int c = 0; c < M; c++)
            for (int k = 0; k < K; k++)
                act_i[(c*K+k)*DW +: DW] = 8'(ab - 8'(c*5) + 8'(k*7));
    endtask

    task automatic model_step(logic vld, logic clr);
        if (vld)
            for (int r = 0; r < N; r++)
                for (int c = 0; c < M; c++)
                    mdl[r][c] = clr ? dot_of(r, c) : mdl[r][c] + dot_of(r, c);
    endtask

    task automatic check_row(int r, string tag);
        logic [M*AW-1:0] exp_row;
        for (int c = 0; c < M; c++) exp_row[c*AW +: AW] = mdl[r][c];
        rd_row = RW'(r);
        #0.2;
        checks++;
        if (rd_data !== exp_row) begin
            errors++;
            $display("FAIL %s row %0d: actual=%h expected=%h", tag, r, rd_data, exp_row);
        end
    endtask

    task automatic check_all(string tag);
        for (int r = 0; r < N; r++) check_row(r, tag);
    endtask

    // Drive one operand cycle, confirm no early update, then compare all rows.
    task automatic step(logic vld, logic clr, string tag);
        @(negedge clk);
        in_valid = vld;
        in_clear = clr;
        check_row(0, "R9 before edge");
        model_step(vld, clr);
        @(negedge clk);
        in_valid = 1'b0;
        in_clear = 1'b0;
        check_all(tag);
    endtask

    initial begin
        for (int r = 0; r < N; r++)
            for (int c = 0; c < M; c++) mdl[r][c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // Table walk: R2 load, R3 add, R4 idle ignored, R7 lane pairing, R8 readout
        for (int i = 0; i < NV; i++) begin
            set_ops(TBL[i].wb, TBL[i].ab);
            step(TBL[i].vld, TBL[i].clr,
                 TBL[i].vld ? (TBL[i].clr ? "R2 load" : "R3 add R7") : "R4 idle");
        end

        // R7: one nonzero weight row and one nonzero activation column
        wgt_i = '0; act_i = '0;
        wgt_i[(2*K+1)*DW +: DW] = 8'd9;
        act_i[(5*K+1)*DW +: DW] = 8'hFD;
        step(1'b1, 1'b1, "R7 isolated cell");

        // R5: signed extremes
        wgt_i = {N*K{8'h80}}; act_i = {M*K{8'h80}};
        step(1'b1, 1'b1, "R5 neg*neg");
        act_i = {M*K{8'h7F}};
        step(1'b1, 1'b1, "R5 neg*pos");

        // R4: clear asserted without valid, operands changed
        wgt_i = {N*K{8'h11}};
        step(1'b0, 1'b1, "R4 clear ignored");

        // R6: wrap, load 65536 then add it 65535 more times
        wgt_i = {N*K{8'h80}}; act_i = {M*K{8'h80}};
        step(1'b1, 1'b1, "R6 preload");
        @(negedge clk);
        in_valid = 1'b1;
        in_clear = 1'b0;
        for (int i = 0; i < 65534; i++) begin
            model_step(1'b1, 1'b0);
            @(negedge clk);
        end
        model_step(1'b1, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        check_all("R6 wrap to zero");
        step(1'b1, 1'b0, "R6 after wrap");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule